// File: doc/BRIEF.md
# Carry-Flag Bit Manipulation Unit

This unit executes single-bit Boolean instructions that work between the carry flag (CY) and one addressed bit. A decoder hands it one request at a time: an operation, an operand class, a 3-bit bit index, an address, and a flag that says whether the target is internal high-speed RAM. The unit keeps CY itself. It reads memory operands over a byte-wide bus with a ready handshake. It either updates CY or writes the modified byte back to memory, to the accumulator or to the status word.

A request is taken on a rising edge where `req_valid` is high and `busy` is low. From the next cycle, `busy` stays high for exactly the number of clocks that the instruction form costs. Every bus cycle spent waiting for `mem_ready` lengthens that period by two clocks. The last busy cycle carries a one-cycle `done` pulse.

Top module: `cy_bit_unit`

## Requirements
- R1: Operation codes are load 0 (CY gets bit), AND 2, OR 3 and XOR 4 (CY combined with the bit). The new CY appears on `cy` in the cycle after `done`. CY changes at no other time.
- R2: Store (operation 1) with a memory class is a read-modify-write. The unit reads the byte at `req_addr`, then writes to the same address the same byte with only bit `req_bit` replaced by CY. The memory classes are short-direct 0, special register 1 and HL-indirect 4.
- R3: Store with accumulator class 2 pulses `acc_we` together with `done`. `acc_wdata` is `acc_i` with bit `req_bit` replaced by CY.
- R4: Store with status-word class 3 pulses `psw_we` together with `done`. `psw_wdata` is `psw_i` with bit `req_bit` replaced by CY, so the other flags can change. When reading the status word, bit 0 is CY itself.
- R5: With no wait states, `busy` lasts this many cycles:
  - 8 for accumulator forms.
  - 12 for short-direct or HL-indirect forms when `req_int_ram` is 1.
  - 14 for every other read form.
  - 16 for every other store form.
- R6: Each cycle in which `mem_req` is high and `mem_ready` is low adds two cycles to the busy period.
- R7: `done` is high for exactly one cycle, the last busy cycle. `busy` is low in the cycle that follows.
- R8: A request that arrives while busy is ignored. A request with operation code 5 to 7 or class code 5 to 7 is ignored and does not start the unit.
- R9: After reset, `busy`, `done`, `mem_req` and `cy` are all 0.
- R10: Store leaves CY unchanged. Load, AND, OR and XOR write nothing: there is no memory write and no `acc_we` or `psw_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code |
| req_src | input | 3 | Operand class code |
| req_bit | input | 3 | Bit index in the operand byte |
| req_addr | input | ADDR_W | Operand address for memory classes |
| req_int_ram | input | 1 | Target is internal high-speed RAM |
| acc_i | input | 8 | Current accumulator |
| psw_i | input | 8 | Current status word |
| mem_req | output | 1 | Bus access active |
| mem_we | output | 1 | Bus access is a write |
| mem_addr | output | ADDR_W | Bus address |
| mem_wdata | output | 8 | Bus write byte |
| mem_rdata | input | 8 | Bus read byte |
| mem_ready | input | 1 | Bus access completes this cycle |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | 8 | New accumulator value |
| psw_we | output | 1 | Status word write strobe |
| psw_wdata | output | 8 | New status word value |
| cy | output | 1 | Carry flag |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction completes this cycle |

## Verification
`busy` rises in the first cycle after the accepting edge. The bench samples on falling edges and counts busy cycles from there. It compares the count with the base cost plus twice the wait cycles that its own bus model inserted. Register write strobes are due in the same cycle as `done`, and the bench records them on the falling edge of that cycle. The new CY is due one cycle later, so the bench reads `cy` at the first falling edge where `busy` is low again. Memory writes land mid-instruction and are checked in the bench's memory image once the instruction ends.

// File: rtl/cy_bit_unit.sv
module cy_bit_unit #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [2:0]        req_src,
  input  logic [2:0]        req_bit,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_int_ram,
  input  logic [7:0]        acc_i,
  input  logic [7:0]        psw_i,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready,
  output logic              acc_we,
  output logic [7:0]        acc_wdata,
  output logic              psw_we,
  output logic [7:0]        psw_wdata,
  output logic              cy,
  output logic              busy,
  output logic              done
);

  localparam logic [2:0] OP_LD  = 3'd0;
  localparam logic [2:0] OP_ST  = 3'd1;
  localparam logic [2:0] OP_AND = 3'd2;
  localparam logic [2:0] OP_OR  = 3'd3;
  localparam logic [2:0] OP_XOR = 3'd4;

  localparam logic [2:0] SRC_SADDR = 3'd0;
  localparam logic [2:0] SRC_SFR   = 3'd1;
  localparam logic [2:0] SRC_ACC   = 3'd2;
  localparam logic [2:0] SRC_PSW   = 3'd3;
  localparam logic [2:0] SRC_HL    = 3'd4;

  localparam logic [2:0] CY_POS = 3'd0;

  typedef enum logic [1:0] {PH_NONE, PH_RD, PH_WR} phase_t;

  phase_t            phase_q;
  logic              busy_q, cy_q, opb_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [2:0]        op_q, src_q, bit_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        byte_q, patched, loc_byte;
  logic [4:0]        base_c;
  logic              req_ok, accept, req_mem, loc_bit, stall, new_cy;

  assign req_ok  = (req_op <= OP_XOR) && (req_src <= SRC_HL);
  assign accept  = req_valid && !busy_q && req_ok;
  assign req_mem = (req_src == SRC_SADDR) || (req_src == SRC_SFR) || (req_src == SRC_HL);

  assign loc_byte = (req_src == SRC_PSW) ? psw_i : acc_i;
  assign loc_bit  = (req_src == SRC_PSW && req_bit == CY_POS) ? cy_q : loc_byte[req_bit];

  always_comb begin
    if (req_src == SRC_ACC)
      base_c = 5'd8;
    else if ((req_src == SRC_SADDR || req_src == SRC_HL) && req_int_ram)
      base_c = 5'd12;
    else if (req_op == OP_ST)
      base_c = 5'd16;
    else
      base_c = 5'd14;
  end

  always_comb begin
    patched = byte_q;
    patched[bit_q] = cy_q;
  end

  always_comb begin
    case (op_q)
      OP_LD:   new_cy = opb_q;
      OP_AND:  new_cy = cy_q & opb_q;
      OP_OR:   new_cy = cy_q | opb_q;
      OP_XOR:  new_cy = cy_q ^ opb_q;
      default: new_cy = cy_q;
    endcase
  end

  assign mem_req   = busy_q && (phase_q != PH_NONE);
  assign mem_we    = busy_q && (phase_q == PH_WR);
  assign mem_addr  = addr_q;
  assign mem_wdata = patched;
  assign stall     = mem_req && !mem_ready;
  assign done      = busy_q && (cnt_q == '0);
  assign busy      = busy_q;
  assign cy        = cy_q;
  assign acc_we    = done && op_q == OP_ST && src_q == SRC_ACC;
  assign psw_we    = done && op_q == OP_ST && src_q == SRC_PSW;
  assign acc_wdata = patched;
  assign psw_wdata = patched;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cy_q    <= 1'b0;
      opb_q   <= 1'b0;
      cnt_q   <= '0;
      phase_q <= PH_NONE;
      op_q    <= OP_LD;
      src_q   <= SRC_ACC;
      bit_q   <= 3'd0;
      addr_q  <= '0;
      byte_q  <= 8'd0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      cnt_q   <= CNT_W'(base_c) - CNT_W'(1);
      op_q    <= req_op;
      src_q   <= req_src;
      bit_q   <= req_bit;
      addr_q  <= req_addr;
      byte_q  <= loc_byte;
      opb_q   <= loc_bit;
      phase_q <= req_mem ? PH_RD : PH_NONE;
    end else if (busy_q) begin
      if (stall)
        cnt_q <= cnt_q + CNT_W'(1);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - CNT_W'(1);
      if (done) begin
        busy_q <= 1'b0;
        cy_q   <= new_cy;
      end
      case (phase_q)
        PH_RD: if (mem_ready) begin
          byte_q  <= mem_rdata;
          opb_q   <= mem_rdata[bit_q];
          phase_q <= (op_q == OP_ST) ? PH_WR : PH_NONE;
        end
        PH_WR: if (mem_ready) phase_q <= PH_NONE;
        default: phase_q <= PH_NONE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy); // R7
  AST_BUS_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_req); // R2
  AST_BUS_DONE_FIRST: assert property (@(posedge clk) disable iff (!rst_n) done |-> !mem_req); // R6
  AST_CY_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) !done |=> $stable(cy)); // R1
  AST_STORE_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n) (done && op_q == OP_ST) |=> $stable(cy)); // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({acc_we, psw_we, mem_we})); // R3
  AST_IDLE_NO_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !(acc_we || psw_we)); // R4

endmodule

// File: tb/cy_bit_unit_bench.sv
`timescale 1ns/1ps
module cy_bit_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_int_ram = 1'b0;
  logic [2:0] req_op = '0, req_src = '0, req_bit = '0;
  logic [15:0] req_addr = '0;
  logic [7:0] acc_i = '0, psw_i = '0, mem_rdata = '0;
  logic mem_ready = 1'b0;
  logic mem_req, mem_we, acc_we, psw_we, cy, busy, done;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, acc_wdata, psw_wdata;

  cy_bit_unit u_cy_bit_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_src(req_src),
    .req_bit(req_bit), .req_addr(req_addr), .req_int_ram(req_int_ram), .acc_i(acc_i), .psw_i(psw_i),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .psw_we(psw_we), .psw_wdata(psw_wdata), .cy(cy), .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] mem [256];
  int rd_w, wr_w, acc_idx, wait_left, nwaits, mem_wr_cnt, acc_cnt, psw_cnt, done_cnt;
  bit fresh = 1;
  logic [15:0] wr_addr;
  logic [7:0] acc_seen, psw_seen;
  logic exp_cy = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      fresh = 1;
    end else if (mem_req) begin
      if (fresh) begin
        wait_left = (acc_idx == 0) ? rd_w : wr_w;
        acc_idx++;
        fresh = 0;
      end
      if (wait_left > 0) begin
        wait_left--;
        nwaits++;
        mem_ready <= 1'b0;
      end else begin
        mem_ready <= 1'b1;
        mem_rdata <= mem[mem_addr[7:0]];
        if (mem_we) begin
          mem[mem_addr[7:0]] = mem_wdata;
          wr_addr = mem_addr;
          mem_wr_cnt++;
        end
        fresh = 1;
      end
    end else begin
      mem_ready <= 1'b0;
      fresh = 1;
    end
    if (acc_we) begin acc_cnt++; acc_seen = acc_wdata; end
    if (psw_we) begin psw_cnt++; psw_seen = psw_wdata; end
    if (done) done_cnt++;
  end

  function automatic int base_cost(input int op, input int src, input bit ir);
    if (src == 2) return 8;
    if ((src == 0 || src == 4) && ir) return 12;
    return (op == 1) ? 16 : 14;
  endfunction

  task automatic run_op(input int op, input int src, input int b, input logic [15:0] addr,
                        input bit ir, input int rw, input int ww, input bit inj);
    logic [7:0] orig, expb;
    logic opnd;
    int cycles;
    bit is_mem = (src == 0 || src == 1 || src == 4);
    orig = (src == 2) ? acc_i : (src == 3) ? psw_i : mem[addr[7:0]];
    opnd = (src == 3 && b == 0) ? exp_cy : orig[b];
    expb = orig; expb[b] = exp_cy;
    @(negedge clk);
    rd_w = rw; wr_w = ww; acc_idx = 0; nwaits = 0; mem_wr_cnt = 0;
    acc_cnt = 0; psw_cnt = 0; done_cnt = 0;
    req_op = 3'(op); req_src = 3'(src); req_bit = 3'(b); req_addr = addr;
    req_int_ram = ir; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cycles = 0;
    while (busy && cycles < 1000) begin
      cycles++;
      if (inj && cycles == 2) begin req_valid = 1'b1; req_op = 3'd1; req_src = 3'd2; end
      else req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
    case (op)
      0: exp_cy = opnd;
      2: exp_cy = exp_cy & opnd;
      3: exp_cy = exp_cy | opnd;
      4: exp_cy = exp_cy ^ opnd;
      default: ;
    endcase
    check(cycles == base_cost(op, src, ir) + 2 * nwaits, "R5/R6 busy length", cycles, base_cost(op, src, ir) + 2 * nwaits);
    check(done_cnt == 1, "R7 single done", done_cnt, 1);
    check(cy == exp_cy, (op == 1) ? "R10 store keeps cy" : "R1 cy result", int'(cy), int'(exp_cy));
    if (op == 1 && is_mem) begin
      check(mem_wr_cnt == 1 && wr_addr == addr, "R2 one write to operand address", int'(wr_addr), int'(addr));
      check(mem[addr[7:0]] == expb, "R2 only indexed bit replaced", int'(mem[addr[7:0]]), int'(expb));
    end else if (op == 1 && src == 2) begin
      check(acc_cnt == 1 && acc_seen == expb, "R3 accumulator store", int'(acc_seen), int'(expb));
    end else if (op == 1 && src == 3) begin
      check(psw_cnt == 1 && psw_seen == expb, "R4 status word store", int'(psw_seen), int'(expb));
    end else begin
      check(mem_wr_cnt + acc_cnt + psw_cnt == 0, "R10 read ops write nothing", mem_wr_cnt + acc_cnt + psw_cnt, 0);
    end
    if (inj) check(acc_cnt == ((op == 1 && src == 2) ? 1 : 0), "R8 busy request ignored", acc_cnt, (op == 1 && src == 2) ? 1 : 0);
  endtask

  task automatic bad_req(input int op, input int src);
    @(negedge clk);
    done_cnt = 0;
    req_op = 3'(op); req_src = 3'(src); req_bit = 3'd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b0, "R8 bad code not started", int'(busy), 0);
    repeat (3) @(negedge clk);
    check(done_cnt == 0 && cy == exp_cy, "R8 bad code no effect", int'(cy), int'(exp_cy));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req && !cy, "R9 reset state", int'({busy, done, mem_req, cy}), 0);
    rst_n = 1'b1;
    acc_i = 8'h04; psw_i = 8'hA5;
    run_op(0, 2, 2, 16'h0000, 0, 0, 0, 0);
    run_op(2, 2, 0, 16'h0000, 0, 0, 0, 0);
    acc_i = 8'hFF;
    run_op(0, 2, 7, 16'h0000, 0, 0, 0, 0);
    run_op(1, 3, 0, 16'h0000, 0, 0, 0, 0);
    run_op(1, 3, 6, 16'h0000, 0, 0, 0, 0);
    run_op(3, 0, 3, 16'hFE21, 1, 0, 0, 0);
    run_op(4, 1, 5, 16'hFF10, 0, 0, 0, 0);
    run_op(1, 4, 4, 16'h8033, 0, 2, 3, 0);
    run_op(1, 0, 1, 16'hFE40, 1, 0, 0, 1);
    run_op(0, 4, 6, 16'h1234, 0, 3, 0, 1);
    bad_req(5, 2);
    bad_req(0, 6);
    for (int k = 0; k < 80; k++) begin
      acc_i = 8'($urandom); psw_i = 8'($urandom);
      run_op(int'($urandom % 5), int'($urandom % 5), int'($urandom % 8), 16'($urandom),
             1'($urandom), int'($urandom % 4), int'($urandom % 4), ($urandom % 4) == 0);
    end
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule